// File: doc/BRIEF.md
# Serial Bus Controller Interrupt Status and Mask Bank

This block gathers the interrupt sources of a two-wire serial bus controller into one status register, gates them with a mask, and drives a single registered interrupt line. Ten bit positions are defined, and nine of them carry a source. Bit 8 is unused. Two kinds of status bit exist. Level bits stay set for as long as their condition holds. Edge bits latch the rising edge of their source and stay set until software clears them.

Software reaches the bank through a plain 32-bit register port. The port takes a word offset, a write strobe and a read strobe, and returns read data one cycle after the read strobe. The mask cannot be written directly. It can only be read, and two write-only strobe words change it: one clears mask bits and the other sets them.

Top module: `irq_bank`

## Requirements
- R1: Bit positions, shared by status, mask, enable and disable: 0 transfer complete, 1 data, 2 NACK, 3 transfer timeout, 4 monitored slave ready, 5 receive overflow, 6 transmit overflow, 7 receive underflow, 9 arbitration lost. Bit 8 and bits 31:10 always read 0. The word offsets are 4 (status, byte offset 0x10), 8 (mask, 0x20), 9 (enable, 0x24) and 10 (disable, 0x28).
- R2: Edge bits (0, 2, 3, 5, 6, 7, 9) set on a 0-to-1 change of `src_i` and stay set after the source falls. A status write with a 1 in a bit clears it, even while the source is still high. A 0 in the written data leaves that bit unchanged.
- R3: A write to the enable offset clears every mask bit where the written data holds a 1. Other mask bits keep their value.
- R4: A write to the disable offset sets every valid mask bit where the written data holds a 1. Other mask bits keep their value.
- R5: After reset, status reads 0, mask reads 0x2FF and `irq_o` is 0.
- R6: Level bits (1 and 4) are set in every cycle in which their source is high. A write-one-to-clear removes a level bit only if its source is low in that cycle.
- R7: If a rising edge and a write-one-to-clear reach the same edge bit in the same cycle, the bit stays set.
- R8: `irq_o` is 1 exactly when some valid bit is set in status and clear in mask. It is taken from the register state of the previous cycle, so it trails a status or mask change by one cycle.
- R9: Reading the enable offset, the disable offset or an unmapped offset returns 0. Reading status changes nothing. Writes to the mask offset are ignored. Read data appears in the cycle after `reg_rd_i` and holds until the next read.
- R10: The mask has no effect on the status register. Masked sources are still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 10 | Source inputs, indexed by status bit position |
| reg_addr_i | input | 4 | Register word offset |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
The hardest situations to reach are the two same-cycle collisions. In one, a clear hits a level bit whose condition is still high. In the other, a clear hits an edge bit in the very cycle its source rises. Random stimulus rarely lines up a write-one-to-clear with a fresh edge on the same bit. Directed steps therefore drive the source rise and the clear write in a single cycle, and then read status back. A fixed-seed random phase then runs level and edge sources against mixed writes and reads, and a bench model checks the interrupt line and the read data in every cycle.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int SRC_W = 10;

    // Word offsets; software sees byte offset = word offset * 4
    localparam logic [3:0] WOFF_STATUS  = 4'd4;
    localparam logic [3:0] WOFF_MASK    = 4'd8;
    localparam logic [3:0] WOFF_ENABLE  = 4'd9;
    localparam logic [3:0] WOFF_DISABLE = 4'd10;

    localparam logic [SRC_W-1:0] VALID_DEFAULT = 10'h2FF;
    localparam logic [SRC_W-1:0] LEVEL_DEFAULT = 10'h012;

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell #(
    parameter bit IS_VALID = 1'b1,
    parameter bit IS_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic clr_i,
    output logic st_o
);

    typedef struct packed {
        logic st;
        logic prev;
    } cell_t;

    cell_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.prev = src_i;
        if (!IS_VALID) begin
            c_d.st = 1'b0;
        end else if (IS_LEVEL) begin
            c_d.st = src_i | (c_q.st & ~clr_i);
        end else begin
            c_d.st = (src_i & ~c_q.prev) | (c_q.st & ~clr_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign st_o = c_q.st;

    generate
        if (IS_VALID && IS_LEVEL) begin : g_lvl_chk
            // R6: a present condition always shows in the next cycle
            a_r6_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
                src_i |=> st_o);
        end else if (IS_VALID) begin : g_edge_chk
            // R2: a clear without a fresh edge empties the bit
            a_r2_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i && !(src_i && !c_q.prev)) |=> !st_o);
            // R7: a fresh edge beats a simultaneous clear
            a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (src_i && !c_q.prev) |=> st_o);
        end
    endgenerate

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int              W     = 10,
    parameter logic [W-1:0]    VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] mask_o
);

    typedef struct packed {
        logic [W-1:0] mask;
    } mreg_t;

    mreg_t m_d, m_q;

    always_comb begin
        m_d      = m_q;
        m_d.mask = ((m_q.mask | set_i) & ~clr_i) & VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q.mask <= VALID;
        else        m_q      <= m_d;
    end

    assign mask_o = m_q.mask;

    // R3: enable bits leave their mask bits at zero
    a_r3_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((mask_o & $past(clr_i)) == '0));

    // R4: disable bits raise their valid mask bits
    a_r4_disable_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i != '0) && (clr_i == '0)) |=>
        ((mask_o & $past(set_i) & VALID) == ($past(set_i) & VALID)));

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int W      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [W-1:0]      st_i,
    input  logic [W-1:0]      mask_i,
    output logic [W-1:0]      st_clr_o,
    output logic [W-1:0]      mask_en_o,
    output logic [W-1:0]      mask_dis_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int PAD_W = DATA_W - W;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } port_t;

    port_t p_d, p_q;
    logic  unused_hi;

    assign unused_hi = ^wdata_i[DATA_W-1:W];

    always_comb begin
        st_clr_o   = '0;
        mask_en_o  = '0;
        mask_dis_o = '0;
        if (wr_i) begin
            unique case (addr_i)
                ADDR_W'(WOFF_STATUS):  st_clr_o   = wdata_i[W-1:0];
                ADDR_W'(WOFF_ENABLE):  mask_en_o  = wdata_i[W-1:0];
                ADDR_W'(WOFF_DISABLE): mask_dis_o = wdata_i[W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        p_d = p_q;
        if (rd_i) begin
            unique case (addr_i)
                ADDR_W'(WOFF_STATUS): p_d.rdata = {{PAD_W{1'b0}}, st_i};
                ADDR_W'(WOFF_MASK):   p_d.rdata = {{PAD_W{1'b0}}, mask_i};
                default:              p_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign rdata_o = p_q.rdata;

    // R9: strobe offsets read back as zero
    a_r9_strobe_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && ((addr_i == ADDR_W'(WOFF_ENABLE)) || (addr_i == ADDR_W'(WOFF_DISABLE))))
        |=> (rdata_o == '0));

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner #(
    parameter int           W     = 10,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] st_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);

    typedef struct packed {
        logic irq;
    } comb_t;

    comb_t q_d, q_q;

    always_comb begin
        q_d     = q_q;
        q_d.irq = |(st_i & ~mask_i & VALID);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign irq_o = q_q.irq;

    // R8: a fully masked bank keeps the line low
    a_r8_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_i & VALID) == VALID) |=> !irq_o);

    // R8: no status at all keeps the line low
    a_r8_no_status_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_i & VALID) == '0) |=> !irq_o);

endmodule

// File: rtl/irq_bank.sv
module irq_bank
    import irq_bank_pkg::*;
#(
    parameter int              ADDR_W     = 4,
    parameter int              DATA_W     = 32,
    parameter int              NSRC       = SRC_W,
    parameter logic [NSRC-1:0] VALID_BITS = VALID_DEFAULT,
    parameter logic [NSRC-1:0] LEVEL_BITS = LEVEL_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);

    logic [NSRC-1:0] st;
    logic [NSRC-1:0] mask;
    logic [NSRC-1:0] st_clr;
    logic [NSRC-1:0] mask_en;
    logic [NSRC-1:0] mask_dis;

    irq_reg_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .W      (NSRC)
    ) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (reg_addr_i),
        .wr_i       (reg_wr_i),
        .rd_i       (reg_rd_i),
        .wdata_i    (reg_wdata_i),
        .st_i       (st),
        .mask_i     (mask),
        .st_clr_o   (st_clr),
        .mask_en_o  (mask_en),
        .mask_dis_o (mask_dis),
        .rdata_o    (reg_rdata_o)
    );

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            irq_src_cell #(
                .IS_VALID (VALID_BITS[i]),
                .IS_LEVEL (LEVEL_BITS[i])
            ) u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .src_i (src_i[i]),
                .clr_i (st_clr[i]),
                .st_o  (st[i])
            );
        end
    endgenerate

    irq_mask_reg #(
        .W     (NSRC),
        .VALID (VALID_BITS)
    ) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (mask_dis),
        .clr_i  (mask_en),
        .mask_o (mask)
    );

    irq_combiner #(
        .W     (NSRC),
        .VALID (VALID_BITS)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .st_i   (st),
        .mask_i (mask),
        .irq_o  (irq_o)
    );

    // R10: the mask never alters status
    a_r10_mask_no_status: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_en != '0 || mask_dis != '0) && st_clr == '0 && $stable(src_i) && (src_i & ~LEVEL_BITS) == '0)
        |=> ((st & ~LEVEL_BITS) == ($past(st) & ~LEVEL_BITS)));

    // R1: the unused position never reports
    a_r1_unused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((st & ~VALID_BITS) == '0) && ((mask & ~VALID_BITS) == '0));

endmodule

// File: tb/sim_irq_bank.sv
`timescale 1ns/1ps
module sim_irq_bank;

    localparam logic [9:0] VAL = 10'h2FF;
    localparam logic [9:0] LVL = 10'h012;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  src = '0;
    logic [3:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;

    logic [9:0]  m_st = '0;
    logic [9:0]  m_mask = VAL;
    logic [9:0]  m_prev = '0;
    logic [31:0] m_rdata = '0;
    logic [9:0]  hold_src = '0;

    always #4 clk = ~clk;

    irq_bank u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    function automatic logic [31:0] model_read(input logic [3:0] a);
        if (a == 4'd4) return {22'd0, m_st};
        if (a == 4'd8) return {22'd0, m_mask};
        return 32'd0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [9:0] s, input logic w, input logic r,
                        input logic [3:0] a, input logic [31:0] d);
        logic        exp_irq;
        logic [9:0]  clr, en, dis, ev;
        @(negedge clk);
        src = s; wr = w; rd = r; addr = a; wdata = d;
        exp_irq = |(m_st & ~m_mask & VAL);
        if (r) m_rdata = model_read(a);
        clr = (w && a == 4'd4)  ? d[9:0] : '0;
        en  = (w && a == 4'd9)  ? d[9:0] : '0;
        dis = (w && a == 4'd10) ? d[9:0] : '0;
        ev  = s & ~m_prev;
        m_st   = ((s & LVL) | (ev & ~LVL) | (m_st & ~clr)) & VAL;
        m_mask = ((m_mask | dis) & ~en) & VAL;
        m_prev = s;
        @(posedge clk);
        #1;
        chk("R8 irq", {31'd0, irq}, {31'd0, exp_irq});
        chk("R9 rdata", rdata, m_rdata);
    endtask

    task automatic idle();
        step(hold_src, 1'b0, 1'b0, 4'd0, 32'd0);
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
        step(hold_src, 1'b0, 1'b1, a, 32'd0);
        chk(tag, rdata, exp);
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        step(hold_src, 1'b1, 1'b0, a, d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R5 irq at reset", {31'd0, irq}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        rd_chk(4'd8, 32'h2FF, "R5 mask reset");
        rd_chk(4'd4, 32'h000, "R5 status reset");

        // R2: edge latch on bit 0
        hold_src = 10'h001; idle();
        hold_src = 10'h000; idle();
        rd_chk(4'd4, 32'h001, "R2 edge sticky");
        wr_reg(4'd4, 32'h000);
        rd_chk(4'd4, 32'h001, "R2 write zero no effect");
        hold_src = 10'h001; idle();
        wr_reg(4'd4, 32'h001);
        rd_chk(4'd4, 32'h000, "R2 clear while source high");
        hold_src = 10'h000; idle();

        // R7: rise and clear together on bit 2
        step(10'h004, 1'b1, 1'b0, 4'd4, 32'h004);
        hold_src = 10'h000;
        rd_chk(4'd4, 32'h004, "R7 event wins");
        wr_reg(4'd4, 32'h004);
        rd_chk(4'd4, 32'h000, "R2 clear bit 2");

        // R6: level bit 1
        hold_src = 10'h002; idle();
        wr_reg(4'd4, 32'h002);
        rd_chk(4'd4, 32'h002, "R6 clear ignored while high");
        hold_src = 10'h000; idle();
        rd_chk(4'd4, 32'h002, "R6 held after fall");
        wr_reg(4'd4, 32'h002);
        rd_chk(4'd4, 32'h000, "R6 clear after fall");

        // R3 and R8
        wr_reg(4'd9, 32'h001);
        rd_chk(4'd8, 32'h2FE, "R3 enable clears bit 0");
        hold_src = 10'h001; idle();
        hold_src = 10'h000; idle();
        chk("R8 irq raised", {31'd0, irq}, 32'd1);

        // R10: masked source still recorded
        hold_src = 10'h004; idle();
        hold_src = 10'h000; idle();
        rd_chk(4'd4, 32'h005, "R10 masked bit recorded");

        // R4 and R8
        wr_reg(4'd10, 32'h001);
        rd_chk(4'd8, 32'h2FF, "R4 disable sets bit 0");
        idle();
        chk("R8 irq low when masked", {31'd0, irq}, 32'd0);

        // R9 and R1
        rd_chk(4'd9, 32'h0, "R9 enable reads zero");
        rd_chk(4'd10, 32'h0, "R9 disable reads zero");
        rd_chk(4'd3, 32'h0, "R9 unmapped reads zero");
        wr_reg(4'd8, 32'h0);
        rd_chk(4'd8, 32'h2FF, "R9 mask write ignored");
        rd_chk(4'd4, 32'h005, "R9 status read once");
        rd_chk(4'd4, 32'h005, "R9 status read no side effect");
        wr_reg(4'd9, 32'h100);
        rd_chk(4'd8, 32'h2FF, "R1 bit 8 mask stays zero");
        hold_src = 10'h100; idle();
        hold_src = 10'h000; idle();
        rd_chk(4'd4, 32'h005, "R1 bit 8 status stays zero");
        hold_src = 10'h200; idle();
        hold_src = 10'h000; idle();
        rd_chk(4'd4, 32'h205, "R1 bit 9 arbitration lost");
        wr_reg(4'd4, 32'hFFFF_FFFF);
        rd_chk(4'd4, 32'h000, "R2 clear all");

        // Random phase, fixed seed
        void'($urandom(32'h1D5E_0042));
        for (int n = 0; n < 4000; n++) begin
            logic [9:0]  s;
            logic [31:0] sel;
            logic [3:0]  a;
            logic        w, r;
            logic [31:0] d;
            s = 10'($urandom) & LVL;
            s |= 10'($urandom) & 10'($urandom) & 10'($urandom) & ~LVL;
            sel = $urandom_range(0, 9);
            w = 1'b0; r = 1'b0; a = 4'd0;
            d = $urandom;
            case (sel)
                0, 1: begin w = 1'b1; a = 4'd4; end
                2:    begin w = 1'b1; a = 4'd9; end
                3:    begin w = 1'b1; a = 4'd10; end
                4:    begin w = 1'b1; a = 4'd8; end
                5, 6: begin r = 1'b1; a = 4'd4; end
                7:    begin r = 1'b1; a = 4'd8; end
                8:    begin r = 1'b1; a = 4'($urandom); end
                default: ;
            endcase
            step(s, w, r, a, d);
        end
        hold_src = '0;
        idle();
        idle();

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule